// File: doc/BRIEF.md
# Serial Command Controller for Four Digital Potentiometer Channels

This block is the serial-side brain of a four-channel digital potentiometer. A host talks to it over a four-wire SPI-style link: an active-low select, a serial clock, a data line in and a data line out. Each transaction opens with one instruction byte, sent most significant bit first. The upper nibble of that byte is the opcode. The next two bits pick a data-register slot. The lowest two bits pick a channel. Depending on the opcode, the block then takes a value byte, returns a byte, moves values between registers, or enters a stepping mode that nudges one wiper up or down on every further serial bit.

Every channel holds a 6-bit wiper setting, which gives 64 taps, and four 6-bit stored settings. The live wiper settings leave the block on a packed output bus and drive the resistor array. Stored settings can be copied to or from the wiper one channel at a time, or on all four channels in a single command. Any command that changes a stored setting starts a timed write cycle. A status command lets the host poll a busy flag that stays set during that cycle.

The serial pins are sampled with the system clock. The serial clock must therefore stay at each level for at least two system clocks. Input bits are taken on rising serial-clock edges, and read data changes on falling edges (mode 0).

Top module: `potCmdTop`

## Requirements
- R1: After reset every wiper and every stored setting is 0, `so` is 0, and a status read returns 0x00.
- R2: Opcode 1010 with slot field 00 and channel P takes a second byte and loads its low 6 bits into wiper P. The two upper bits of that byte are discarded.
- R3: Opcode 1001 with slot field 00 returns wiper P as the second byte on `so`, MSB first, with the value right-justified and bits 7..6 zero. `so` updates on falling serial-clock edges and is 0 whenever select is high.
- R4: Opcode 1100 writes slot R of channel P from the low 6 bits of a second byte. Opcode 1011 returns that slot the same way as R3.
- R5: Opcode 1101 copies slot R of channel P into wiper P. Opcode 1110 copies wiper P into slot R of channel P. No second byte is needed for either.
- R6: With channel field 00, opcode 0001 copies slot R into the wiper on all four channels at once. Opcode 1000 copies every wiper into its own slot R.
- R7: Opcode 0010 with slot field 00 enters stepping mode for channel P. Until select rises, every further rising serial-clock edge raises wiper P by one when `si` is 1 and lowers it by one when `si` is 0.
- R8: In stepping mode a wiper holds at 63 when stepped up and at 0 when stepped down. It never wraps.
- R9: The exact byte 0x51 returns a status byte whose bit 0 is the busy flag and whose other bits are 0. Busy rises on the clock after a stored setting is written (R4 write, 1110, 1000) and stays high for WR_CYCLES clocks.
- R10: An opcode not listed above, a listed opcode with a nonzero field where zero is required, and any byte cut short by select rising all leave every register unchanged and keep `so` at 0.
- R11: Wiper P appears on `wiperOut[6P+5:6P]`. The wipers can change only while select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in, sampled on rising `sck` |
| so | output | 1 | Serial data out, updated on falling `sck` |
| wiperOut | output | 24 | Four packed 6-bit wiper settings, channel 0 in the low bits |

## Verification
A corrupted wiper shows up at once on `wiperOut`, on the clock after the bad update. A corrupted stored setting stays hidden until it is read back, or until a single or global transfer moves it onto `wiperOut`. For that reason the bench follows every stored-setting write with a read or a transfer within the same test. A decoder that acts on a bad opcode, or on a byte cut short by select, is caught by a port-level read or a wiper sample taken straight after the offending transaction. A broken busy timer is caught by status reads taken inside and after the write cycle.

// File: rtl/potCmdPkg.sv
package potCmdPkg;
  localparam int CHAN_W   = 2;
  localparam int REG_W    = 2;
  localparam int VAL_W    = 6;
  localparam int NUM_CHAN = 1 << CHAN_W;
  localparam int NUM_REG  = 1 << REG_W;
  localparam int BYTE_W   = 8;

  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_DATA  = 4'b1011;
  localparam logic [3:0] OP_WR_DATA  = 4'b1100;
  localparam logic [3:0] OP_D2W      = 4'b1101;
  localparam logic [3:0] OP_W2D      = 4'b1110;
  localparam logic [3:0] OP_ALL_D2W  = 4'b0001;
  localparam logic [3:0] OP_ALL_W2D  = 4'b1000;
  localparam logic [3:0] OP_STEP     = 4'b0010;
  localparam logic [7:0] STATUS_BYTE = 8'h51;

  typedef enum logic [2:0] {
    ST_CMD, ST_WRVAL, ST_READ, ST_STEP, ST_IDLE
  } ctrlState_t;

  typedef struct packed {
    logic              wrWiper;
    logic              wrData;
    logic              dataToWiper;
    logic              wiperToData;
    logic              allChan;
    logic              step;
    logic              stepUp;
    logic [CHAN_W-1:0] chan;
    logic [REG_W-1:0]  regSel;
    logic [VAL_W-1:0]  value;
  } potStrobe_t;
endpackage

// File: rtl/potCmdCtrl.sv
module potCmdCtrl
  import potCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  input  logic [VAL_W-1:0]  selWiper,
  input  logic [VAL_W-1:0]  selData,
  input  logic              busy,
  output logic [CHAN_W-1:0] selChan,
  output logic [REG_W-1:0]  selReg,
  output potStrobe_t        cmd
);
  logic              sckPrev;
  logic              sckRise, sckFall;
  logic [2:0]        bitCnt;
  logic [6:0]        shiftIn;
  logic [7:0]        fullByte;
  logic              byteDone;
  ctrlState_t        state, nextState;
  logic [CHAN_W-1:0] savedChan;
  logic [REG_W-1:0]  savedReg;
  logic              savedIsData;
  logic [7:0]        outReg, outVal;
  logic              loadOut;
  logic [3:0]        opc;
  logic [REG_W-1:0]  fieldR;
  logic [CHAN_W-1:0] fieldP;

  assign sckRise  = sck & ~sckPrev & ~csN;
  assign sckFall  = ~sck & sckPrev & ~csN;
  assign fullByte = {shiftIn, si};
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign opc      = fullByte[7:4];
  assign fieldR   = fullByte[3:2];
  assign fieldP   = fullByte[1:0];
  assign selChan  = fieldP;
  assign selReg   = fieldR;

  always_comb begin
    cmd       = '0;
    nextState = state;
    loadOut   = 1'b0;
    outVal    = '0;
    if (sckRise) begin
      case (state)
        ST_CMD: if (byteDone) begin
          nextState  = ST_IDLE;
          cmd.chan   = fieldP;
          cmd.regSel = fieldR;
          case (opc)
            OP_RD_WIPER: if (fieldR == '0) begin
              nextState = ST_READ; loadOut = 1'b1;
              outVal = {{(BYTE_W-VAL_W){1'b0}}, selWiper};
            end
            OP_RD_DATA: begin
              nextState = ST_READ; loadOut = 1'b1;
              outVal = {{(BYTE_W-VAL_W){1'b0}}, selData};
            end
            OP_WR_WIPER: if (fieldR == '0) nextState = ST_WRVAL;
            OP_WR_DATA:  nextState = ST_WRVAL;
            OP_D2W:      cmd.dataToWiper = 1'b1;
            OP_W2D:      cmd.wiperToData = 1'b1;
            OP_ALL_D2W: if (fieldP == '0) begin
              cmd.dataToWiper = 1'b1; cmd.allChan = 1'b1;
            end
            OP_ALL_W2D: if (fieldP == '0) begin
              cmd.wiperToData = 1'b1; cmd.allChan = 1'b1;
            end
            OP_STEP: if (fieldR == '0) nextState = ST_STEP;
            default: if (fullByte == STATUS_BYTE) begin
              nextState = ST_READ; loadOut = 1'b1;
              outVal = {7'b0, busy};
            end
          endcase
        end
        ST_WRVAL: if (byteDone) begin
          cmd.wrWiper = ~savedIsData;
          cmd.wrData  = savedIsData;
          cmd.chan    = savedChan;
          cmd.regSel  = savedReg;
          cmd.value   = fullByte[VAL_W-1:0];
          nextState   = ST_IDLE;
        end
        ST_STEP: begin
          cmd.step   = 1'b1;
          cmd.stepUp = si;
          cmd.chan   = savedChan;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev     <= 1'b0;
      bitCnt      <= '0;
      shiftIn     <= '0;
      state       <= ST_CMD;
      savedChan   <= '0;
      savedReg    <= '0;
      savedIsData <= 1'b0;
      outReg      <= '0;
      so          <= 1'b0;
    end else begin
      sckPrev <= sck;
      if (csN) begin
        state  <= ST_CMD;
        bitCnt <= '0;
        so     <= 1'b0;
      end else begin
        if (sckRise) begin
          bitCnt  <= bitCnt + 3'd1;
          shiftIn <= fullByte[6:0];
          state   <= nextState;
          if (loadOut) outReg <= outVal;
          if (state == ST_CMD && byteDone) begin
            savedChan   <= fieldP;
            savedReg    <= fieldR;
            savedIsData <= (opc == OP_WR_DATA);
          end
        end
        if (sckFall && state == ST_READ) begin
          so     <= outReg[7];
          outReg <= {outReg[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/potCmdRegs.sv
module potCmdRegs
  import potCmdPkg::*;
#(
  parameter int WR_CYCLES = 200
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  potStrobe_t                cmd,
  input  logic [CHAN_W-1:0]         selChan,
  input  logic [REG_W-1:0]          selReg,
  output logic [VAL_W-1:0]          selWiper,
  output logic [VAL_W-1:0]          selData,
  output logic                      busy,
  output logic [NUM_CHAN*VAL_W-1:0] wiperOut
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [VAL_W-1:0] TOP_TAP = '1;

  logic [NUM_CHAN-1:0][VAL_W-1:0]              wiperAll;
  logic [NUM_CHAN-1:0][NUM_REG-1:0][VAL_W-1:0] dataAll;
  logic [CNT_W-1:0]                            busyCnt;

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : gChan
    localparam logic [CHAN_W-1:0] ME = ch[CHAN_W-1:0];
    logic                            hit;
    logic [VAL_W-1:0]                wiperQ;
    logic [NUM_REG-1:0][VAL_W-1:0]   dataQ;

    assign hit = (cmd.chan == ME);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wiperQ <= '0;
        dataQ  <= '0;
      end else begin
        if (cmd.wrWiper && hit)
          wiperQ <= cmd.value;
        else if (cmd.dataToWiper && (cmd.allChan || hit))
          wiperQ <= dataQ[cmd.regSel];
        else if (cmd.step && hit) begin
          if (cmd.stepUp && wiperQ != TOP_TAP) wiperQ <= wiperQ + 1'b1;
          else if (!cmd.stepUp && wiperQ != '0) wiperQ <= wiperQ - 1'b1;
        end
        if (cmd.wrData && hit)
          dataQ[cmd.regSel] <= cmd.value;
        else if (cmd.wiperToData && (cmd.allChan || hit))
          dataQ[cmd.regSel] <= wiperQ;
      end
    end

    assign wiperAll[ch] = wiperQ;
    assign dataAll[ch]  = dataQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (cmd.wrData || cmd.wiperToData) busyCnt <= CNT_W'(WR_CYCLES);
    else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
  end

  assign busy     = (busyCnt != '0);
  assign selWiper = wiperAll[selChan];
  assign selData  = dataAll[selChan][selReg];
  assign wiperOut = wiperAll;
endmodule

// File: rtl/potCmdTop.sv
module potCmdTop
  import potCmdPkg::*;
#(
  parameter int WR_CYCLES = 200
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      sck,
  input  logic                      si,
  output logic                      so,
  output logic [NUM_CHAN*VAL_W-1:0] wiperOut
);
  potStrobe_t        cmd;
  logic              busy;
  logic [CHAN_W-1:0] selChan;
  logic [REG_W-1:0]  selReg;
  logic [VAL_W-1:0]  selWiper, selData;

  potCmdCtrl ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .so(so),
    .selWiper(selWiper), .selData(selData), .busy(busy),
    .selChan(selChan), .selReg(selReg), .cmd(cmd)
  );

  potCmdRegs #(.WR_CYCLES(WR_CYCLES)) regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .selChan(selChan), .selReg(selReg),
    .selWiper(selWiper), .selData(selData), .busy(busy), .wiperOut(wiperOut)
  );
endmodule

// File: rtl/potCmdTop_chk.sv
module potCmdTop_chk
  import potCmdPkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      csN,
  input logic                      so,
  input logic [NUM_CHAN*VAL_W-1:0] wiperOut,
  input logic                      dataWrite,
  input logic                      stepEn,
  input logic                      stepUp,
  input logic [CHAN_W-1:0]         stepChan,
  input logic                      busy
);
  function automatic logic [VAL_W-1:0] laneOf(input logic [NUM_CHAN*VAL_W-1:0] v,
                                              input logic [CHAN_W-1:0] c);
    return v[int'(c)*VAL_W +: VAL_W];
  endfunction

  AST_WIPER_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> $stable(wiperOut)); // R11
  AST_SO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !so); // R3
  AST_BUSY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |=> busy); // R9
  AST_BUSY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(dataWrite)); // R9
  AST_STEP_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !stepUp && laneOf(wiperOut, stepChan) == '0)
      |=> laneOf(wiperOut, $past(stepChan)) == '0); // R8
  AST_STEP_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && stepUp && laneOf(wiperOut, stepChan) == '1)
      |=> laneOf(wiperOut, $past(stepChan)) == '1); // R8
endmodule

bind potCmdTop potCmdTop_chk chk (
  .clk(clk), .rstN(rstN), .csN(csN), .so(so), .wiperOut(wiperOut),
  .dataWrite(cmd.wrData || cmd.wiperToData),
  .stepEn(cmd.step), .stepUp(cmd.stepUp), .stepChan(cmd.chan), .busy(busy)
);

// File: tb/potCmdTop_test.sv
module potCmdTop_test;
  localparam int HALF = 4;
  localparam int WRC  = 200;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic so;
  logic [23:0] wiperOut;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  potCmdTop #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .so(so), .wiperOut(wiperOut)
  );

  function automatic int lane(input int ch);
    return int'(wiperOut[ch*6 +: 6]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic csBegin();
    @(negedge clk); csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csEnd();
    repeat (HALF) @(negedge clk); csN = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bitOut(input logic b, output logic r);
    si = b;
    repeat (HALF) @(negedge clk);
    r = so;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bitOut(tx[i], rx[i]);
  endtask

  task automatic cmdOnly(input logic [7:0] op);
    logic [7:0] d;
    csBegin(); xferByte(op, d); csEnd();
  endtask

  task automatic cmdWrite(input logic [7:0] op, input logic [7:0] val);
    logic [7:0] d;
    csBegin(); xferByte(op, d); xferByte(val, d); csEnd();
  endtask

  task automatic cmdRead(input logic [7:0] op, output logic [7:0] rx);
    logic [7:0] d;
    csBegin(); xferByte(op, d); xferByte(8'h00, rx); csEnd();
  endtask

  task automatic stepBits(input logic [7:0] op, input int n, input logic [15:0] pat);
    logic [7:0] d;
    logic r;
    csBegin(); xferByte(op, d);
    for (int i = 0; i < n; i++) bitOut(pat[i], r);
    csEnd();
  endtask

  task automatic testReset();
    logic [7:0] rx;
    for (int c = 0; c < 4; c++) check("R1 wiper reset", lane(c), 0);
    check("R1 so reset", int'(so), 0);
    cmdRead(8'h51, rx);
    check("R1 status reset", int'(rx), 0);
  endtask

  task automatic testWiperWriteRead();
    logic [7:0] rx;
    cmdWrite(8'hA2, 8'hEA);
    check("R2 wiper2 low six bits", lane(2), 42);
    check("R11 other lanes untouched", lane(0) + lane(1) + lane(3), 0);
    cmdRead(8'h92, rx);
    check("R3 read wiper2", int'(rx), 42);
  endtask

  task automatic testDataAndBusy();
    logic [7:0] rx;
    cmdWrite(8'hCD, 8'hD1);
    cmdRead(8'h51, rx);
    check("R9 busy during write cycle", int'(rx), 1);
    cmdRead(8'hBD, rx);
    check("R4 read data ch1 slot3", int'(rx), 17);
    repeat (WRC + 50) @(negedge clk);
    cmdRead(8'h51, rx);
    check("R9 busy cleared", int'(rx), 0);
  endtask

  task automatic testSingleTransfer();
    logic [7:0] rx;
    cmdOnly(8'hDD);
    check("R5 slot to wiper ch1", lane(1), 17);
    cmdOnly(8'hE2);
    cmdRead(8'hB2, rx);
    check("R5 wiper to slot ch2", int'(rx), 42);
  endtask

  task automatic testGlobal();
    logic [7:0] rx;
    for (int c = 0; c < 4; c++) cmdWrite(8'hC4 | 8'(c), 8'(10 * (c + 1)));
    cmdOnly(8'h14);
    for (int c = 0; c < 4; c++) check("R6 all slots to wipers", lane(c), 10 * (c + 1));
    cmdOnly(8'h88);
    for (int c = 0; c < 4; c++) begin
      cmdRead(8'hB8 | 8'(c), rx);
      check("R6 all wipers to slot2", int'(rx), 10 * (c + 1));
    end
  endtask

  task automatic testStep();
    stepBits(8'h20, 4, 16'b0111);
    check("R7 step ch0 up3 down1", lane(0), 12);
    check("R7 ch1 untouched", lane(1), 20);
    cmdWrite(8'hA3, 8'd62);
    stepBits(8'h23, 4, 16'b1111);
    check("R8 ceiling hold", lane(3), 63);
    cmdWrite(8'hA3, 8'd1);
    stepBits(8'h23, 3, 16'b000);
    check("R8 floor hold", lane(3), 0);
  endtask

  task automatic testIgnored();
    logic [7:0] rx;
    logic [7:0] d;
    logic r;
    cmdRead(8'h94, rx);
    check("R10 read with nonzero slot", int'(rx), 0);
    cmdWrite(8'hA4, 8'h05);
    check("R10 write with nonzero slot", lane(0), 12);
    cmdWrite(8'hF0, 8'h07);
    check("R10 unknown opcode", lane(0), 12);
    cmdOnly(8'h15);
    check("R10 global with nonzero channel", lane(0), 12);
    stepBits(8'h24, 4, 16'b1111);
    check("R10 step with nonzero slot", lane(0), 12);
    csBegin(); xferByte(8'hA0, d);
    for (int i = 0; i < 4; i++) bitOut(1'b1, r);
    csEnd();
    check("R10 value byte cut short", lane(0), 12);
    csBegin();
    for (int i = 0; i < 5; i++) bitOut(1'b1, r);
    csEnd();
    cmdRead(8'h90, rx);
    check("R10 realign after short byte", int'(rx), 12);
  endtask

  task automatic testDeselected();
    logic r;
    for (int i = 0; i < 10; i++) bitOut(1'b1, r);
    check("R11 wiper0 stable deselected", lane(0), 12);
    check("R3 so low deselected", int'(so), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testWiperWriteRead();
    testDataAndBusy();
    testSingleTransfer();
    testGlobal();
    testStep();
    testIgnored();
    testDeselected();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule